// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address. It also decides whether the fetch may execute under the current privilege level. It holds a direct-mapped table with one way. Each slot holds a tag word and a frame word, and software loads both through a dedicated write port. The page number of the fetch address selects one slot. The tag comparison, the valid check and the execute-right check all happen in the cycle of the request, and the outcome appears on registered outputs one cycle later.

The core's fetch unit raises a request strobe together with the address and its supervisor flag. It reads back a 2-bit outcome code, a permission flag and the translated address. Refill after a miss, exception dispatch and any replacement policy belong to the surrounding logic.

Top module: `itlb_lookup`

## Requirements
- R1: While reset is held and after it is released, resultValid, resultCode, execOk and physAddr are all zero, and every slot's valid flag is cleared, so a lookup of page 0 returns code 10 and any other page returns code 01.
- R2: The page number is fetchAddr shifted right by PAGE_BITS. The slot used is the low log2(ENTRIES) bits of that page number.
- R3: When the stored tag of the selected slot (tag word bits ADDR_W-1 down to PAGE_BITS) differs from the full page number, the code is 01 (no-match).
- R4: When the tag is equal but the valid flag (tag word bit 0) is clear, the code is 10 (invalid).
- R5: When supervisor is high, execute right comes from frame word bit 1. When it is low, execute right comes from frame word bit 2.
- R6: A valid, tag-equal lookup without execute right gives code 11 (bad-address). For every code other than 00, execOk is 0 and physAddr is 0.
- R7: A valid, tag-equal lookup with execute right gives code 00 and execOk 1. physAddr is frame word bits ADDR_W-1 down to PAGE_BITS followed by the fetch address bits PAGE_BITS-1 down to 0.
- R8: The outputs for a request sampled at a rising edge appear right after that edge, and resultValid is high for exactly that one cycle. After a cycle without a request, resultValid is low and the other outputs keep their values.
- R9: When wrEn is high, wrData is written at the rising edge into slot wrIdx. wrSel 0 selects the tag word and wrSel 1 selects the frame word. A lookup in the same cycle as a write sees the slot contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Lookup request strobe |
| fetchAddr | input | ADDR_W | Virtual fetch address |
| supervisor | input | 1 | High for supervisor privilege |
| wrEn | input | 1 | Slot write enable |
| wrSel | input | 1 | 0 selects the tag word, 1 selects the frame word |
| wrIdx | input | log2(ENTRIES) | Slot written |
| wrData | input | ADDR_W | Word written |
| resultValid | output | 1 | Outcome of the previous cycle's request is present |
| resultCode | output | 2 | 00 match, 01 no-match, 10 invalid, 11 bad-address |
| execOk | output | 1 | Execute right granted |
| physAddr | output | ADDR_W | Translated address, zero unless code 00 |

## Verification
Some properties are checked by assertions on every cycle. resultValid tracks the previous cycle's request. A failed lookup never reports a permission or an address. A successful lookup carries execute right and keeps the fetch offset unchanged. Which code a given page produces depends on the slot contents, the supervisor/user choice of permission bit, and the old-contents rule for a write and a lookup in the same cycle. Only the bench scenarios can show these: they sweep every page number in both privilege modes against a reference table kept in the bench.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  typedef enum logic [1:0] {
    RES_MATCH   = 2'b00,
    RES_NOMATCH = 2'b01,
    RES_INVALID = 2'b10,
    RES_BADADDR = 2'b11
  } itlbRes_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrTag;
    logic wrFrame;
    logic capture;
  } itlbStrb_t;

  // Bit positions inside the stored words
  localparam int VALID_BIT = 0;
  localparam int SUP_X_BIT = 1;
  localparam int USR_X_BIT = 2;

endpackage

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchReq,
  input  logic      wrEn,
  input  logic      wrSel,
  output itlbStrb_t strb,
  output logic      resultValid
);

  always_comb begin
    strb.wrTag   = wrEn && !wrSel;
    strb.wrFrame = wrEn && wrSel;
    strb.capture = fetchReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= fetchReq;
  end

  AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> resultValid); // R8
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |=> !resultValid); // R8

endmodule

// File: rtl/itlb_datapath.sv
module itlb_datapath
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  itlbStrb_t         strb,
  input  logic              resultValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              supervisor,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrData,
  output logic [1:0]        resultCode,
  output logic              execOk,
  output logic [ADDR_W-1:0] physAddr
);

  // Slot storage, split into the fields that are read
  logic [VPN_W-1:0] tagVpn   [ENTRIES];
  logic             tagValid [ENTRIES];
  logic [VPN_W-1:0] frameNum [ENTRIES];
  logic             supExec  [ENTRIES];
  logic             usrExec  [ENTRIES];

  logic unusedWrBits;
  assign unusedWrBits = ^wrData[PAGE_BITS-1:USR_X_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tagVpn[e]   <= '0;
        tagValid[e] <= 1'b0;
        frameNum[e] <= '0;
        supExec[e]  <= 1'b0;
        usrExec[e]  <= 1'b0;
      end
    end else begin
      if (strb.wrTag) begin
        tagVpn[wrIdx]   <= wrData[ADDR_W-1:PAGE_BITS];
        tagValid[wrIdx] <= wrData[VALID_BIT];
      end
      if (strb.wrFrame) begin
        frameNum[wrIdx] <= wrData[ADDR_W-1:PAGE_BITS];
        supExec[wrIdx]  <= wrData[SUP_X_BIT];
        usrExec[wrIdx]  <= wrData[USR_X_BIT];
      end
    end
  end

  // Combinational lookup
  logic [VPN_W-1:0]  vpn;
  logic [IDX_W-1:0]  slot;
  logic              tagEq;
  logic              mayExec;
  itlbRes_e          codeNext;
  logic [ADDR_W-1:0] physNext;

  always_comb begin
    vpn      = fetchAddr[ADDR_W-1:PAGE_BITS];
    slot     = vpn[IDX_W-1:0];
    tagEq    = (tagVpn[slot] == vpn);
    mayExec  = supervisor ? supExec[slot] : usrExec[slot];
    physNext = '0;
    if (!tagEq)               codeNext = RES_NOMATCH;
    else if (!tagValid[slot]) codeNext = RES_INVALID;
    else if (!mayExec)        codeNext = RES_BADADDR;
    else begin
      codeNext = RES_MATCH;
      physNext = {frameNum[slot], fetchAddr[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultCode <= 2'b00;
      execOk     <= 1'b0;
      physAddr   <= '0;
    end else if (strb.capture) begin
      resultCode <= codeNext;
      execOk     <= (codeNext == RES_MATCH);
      physAddr   <= physNext;
    end
  end

  AST_MATCH_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode == RES_MATCH) |-> execOk); // R7
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode != RES_MATCH) |-> (!execOk && physAddr == '0)); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode == RES_MATCH) |->
      physAddr[PAGE_BITS-1:0] == $past(fetchAddr[PAGE_BITS-1:0])); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(resultCode) && $stable(physAddr))); // R8

endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              supervisor,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrData,
  output logic              resultValid,
  output logic [1:0]        resultCode,
  output logic              execOk,
  output logic [ADDR_W-1:0] physAddr
);

  itlbStrb_t strb;

  itlb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fetchReq    (fetchReq),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .strb        (strb),
    .resultValid (resultValid)
  );

  itlb_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .ENTRIES   (ENTRIES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .resultValid (resultValid),
    .fetchAddr   (fetchAddr),
    .supervisor  (supervisor),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .resultCode  (resultCode),
    .execOk      (execOk),
    .physAddr    (physAddr)
  );

endmodule

// File: tb/sim_itlb_lookup.sv
module sim_itlb_lookup;
  localparam int AW  = 12;
  localparam int PB  = 4;
  localparam int ENT = 8;
  localparam int IW  = 3;
  localparam int NPG = 1 << (AW - PB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic supervisor = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [AW-1:0] wrData = '0;
  logic resultValid;
  logic [1:0] resultCode;
  logic execOk;
  logic [AW-1:0] physAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [AW-1:0] tagMod [ENT];
  logic [AW-1:0] frmMod [ENT];

  always #2 clk = ~clk;

  itlb_lookup #(.ADDR_W(AW), .PAGE_BITS(PB), .ENTRIES(ENT)) u0 (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .supervisor(supervisor), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .resultValid(resultValid), .resultCode(resultCode),
    .execOk(execOk), .physAddr(physAddr));

  task automatic check(string tag, logic [AW+3:0] act, logic [AW+3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%b code=%b exec=%b phys=%h, expected valid=%b code=%b exec=%b phys=%h",
               tag, act[AW+3], act[AW+2:AW+1], act[AW], act[AW-1:0],
               exp[AW+3], exp[AW+2:AW+1], exp[AW], exp[AW-1:0]);
    end
  endtask

  function automatic logic [AW+3:0] observed();
    return {resultValid, resultCode, execOk, physAddr};
  endfunction

  // Reference outcome: R2 slot select, R3/R4 tag and valid, R5 mode bit, R6/R7
  function automatic logic [AW+3:0] model(logic [AW-1:0] a, logic sup);
    int pg = int'(a >> PB);
    int s = pg % ENT;
    logic [AW-1:0] t = tagMod[s];
    logic [AW-1:0] f = frmMod[s];
    logic ex;
    if (int'(t >> PB) != pg) return {1'b1, 2'b01, 1'b0, {AW{1'b0}}};
    if (!t[0]) return {1'b1, 2'b10, 1'b0, {AW{1'b0}}};
    ex = sup ? f[1] : f[2];
    if (!ex) return {1'b1, 2'b11, 1'b0, {AW{1'b0}}};
    return {1'b1, 2'b00, 1'b1, ((f >> PB) << PB) | (a & AW'((1 << PB) - 1))};
  endfunction

  function automatic string tagFor(logic [1:0] c);
    case (c)
      2'b00: return "R2 R5 R7";
      2'b01: return "R2 R3";
      2'b10: return "R4";
      default: return "R5 R6";
    endcase
  endfunction

  task automatic lookup(logic [AW-1:0] a, logic sup);
    logic [AW+3:0] e;
    e = model(a, sup);
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a; supervisor = sup;
    @(negedge clk);
    fetchReq = 1'b0;
    check(tagFor(e[AW+2:AW+1]), observed(), e);
  endtask

  task automatic writeWord(logic sel, int idx, logic [AW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = IW'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) frmMod[idx] = d; else tagMod[idx] = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW+3:0] oldExp;
    logic [AW-1:0] a;
    for (int s = 0; s < ENT; s++) begin tagMod[s] = '0; frmMod[s] = '0; end
    repeat (3) @(negedge clk);
    check("R1", observed(), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", observed(), '0);

    // R1: cleared table, every page
    for (int p = 0; p < NPG; p++) lookup(AW'((p << PB) | (p % 16)), 1'b1);

    // Program slots: slot 5 left invalid, permission pattern cycles over slots (R9)
    for (int s = 0; s < ENT; s++) begin
      int pg = s + ENT * ((s * 3) % 32);
      writeWord(1'b0, s, AW'((pg << PB) | (s != 5 ? 1 : 0)));
      writeWord(1'b1, s, AW'((((s * 37 + 11) % NPG) << PB) | ((s % 4) << 1) | 8));
    end

    // Full sweep, both privilege modes
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < NPG; p++)
        lookup(AW'((p << PB) | ((p * 7) % 16)), m[0]);

    // R9: write and lookup in the same cycle see the old slot
    a = AW'(((2 + ENT * 6) << PB) | 3);
    oldExp = model(a, 1'b1);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b1; wrIdx = 3'd2; wrData = AW'((8'hA5 << PB) | 6);
    fetchReq = 1'b1; fetchAddr = a; supervisor = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; fetchReq = 1'b0;
    frmMod[2] = AW'((8'hA5 << PB) | 6);
    check("R9 old contents", observed(), oldExp);
    lookup(a, 1'b1);
    lookup(a, 1'b0);

    // R8: idle cycle drops resultValid, rest held
    oldExp = observed();
    @(negedge clk);
    check("R8 idle", observed(), {1'b0, oldExp[AW+2:0]});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule